// File: doc/BRIEF.md
# Host-Written Transmit Queue Controller

This block sits between a microcontroller's register writes and a packet transmitter. The host loads a packet into a quadlet FIFO through two write ports. The body port takes every quadlet except the last one. The commit port takes the final quadlet, tags it as the end of the packet and raises a transmit request. A bulk-data stream input can also feed the FIFO, but only when the data-select bit picks it. While the host owns the FIFO, that stream is refused.

The FIFO drains toward the transmitter over a valid/ready stream. The transmitter reports completion with an acknowledge code. The block latches that code and raises an acknowledge-valid flag. It then raises an end-of-transaction interrupt. The interrupt is raised at once, unless the code says "pending" and split handling is enabled. In that case the interrupt waits until a response packet is reported.

Back-pressure rules:
- A FIFO entry leaves only on a cycle where `out_valid` and `out_ready` are both 1.
- While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold still.
- The bulk input transfers a beat only on a cycle where `bulk_valid` and `bulk_ready` are both 1.

Top module: `hostq_tx_ctrl`

## Requirements
- R1: The host write path is open only when `cfg_fifo_en`=1, `cfg_pktz`=0, `cfg_hdr_ins`=0 and `cfg_data_sel`=0. In any other mode, host port writes leave the FIFO and all flags unchanged.
- R2: `bulk_ready` equals `cfg_fifo_en & cfg_data_sel & !full`. So when `cfg_data_sel`=0 the bulk stream is locked out. An accepted bulk beat is queued with `bulk_last` as its end tag.
- R3: A body-port write (`host_fc_wr`) queues its quadlet with the end tag at 0. If both ports are written in the same cycle, only the commit write is taken.
- R4: A commit-port write (`host_upd_wr`) queues its quadlet with the end tag at 1. `tx_req` reads 1 from the next cycle on.
- R5: A `done_valid` pulse while `tx_req`=1 clears `tx_req`, sets `ack_valid` and latches `done_ack` into `ack_code`, all visible the next cycle. A `done_valid` pulse while `tx_req`=0 is ignored.
- R6: At completion, `end_irq` is set in the same cycle as `ack_valid` when `cfg_split_dis`=1 or `done_ack` != 4'h2.
- R7: When `cfg_split_dis`=0 and `done_ack`=4'h2 (pending), `end_irq` stays 0 until a `rsp_rcvd` pulse. It is set on the cycle after that pulse.
- R8: `flag_clr` is write-one-to-clear. Bit 0 clears `ack_valid`, bit 1 clears `end_irq`, bit 2 clears `err_busy` and bit 3 clears `err_ovf`. If a set and a clear land in the same cycle, the set wins.
- R9: A write to either host port while a request is outstanding (`tx_req`=1 or a response is still awaited) is discarded and sets `err_busy`.
- R10: A host write to a full FIFO is discarded and sets `err_ovf`. The FIFO never holds more than DEPTH entries.
- R11: The output stream delivers entries in write order. While back-pressured it holds `out_data` and `out_last` stable.
- R12: After reset, the FIFO is empty and `tx_req`, `ack_valid`, `ack_code`, `end_irq`, `err_busy` and `err_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_en | input | 1 | FIFO enable |
| cfg_pktz | input | 1 | Packetizer mode select (host path closed when 1) |
| cfg_hdr_ins | input | 1 | Header insertion select (host path closed when 1) |
| cfg_data_sel | input | 1 | 0: host owns FIFO, 1: bulk stream owns FIFO |
| cfg_split_dis | input | 1 | 1: never defer the end interrupt |
| host_fc_wr | input | 1 | Body-port write strobe |
| host_fc_data | input | DW | Body-port quadlet |
| host_upd_wr | input | 1 | Commit-port write strobe |
| host_upd_data | input | DW | Commit-port (final) quadlet |
| bulk_valid | input | 1 | Bulk stream beat valid |
| bulk_ready | output | 1 | Bulk stream beat accepted |
| bulk_data | input | DW | Bulk stream quadlet |
| bulk_last | input | 1 | Bulk stream end-of-packet tag |
| out_valid | output | 1 | Output stream entry valid |
| out_ready | input | 1 | Output stream consumer ready |
| out_data | output | DW | Output stream quadlet |
| out_last | output | 1 | Output stream end-of-packet tag |
| tx_req | output | 1 | Transmit request outstanding |
| done_valid | input | 1 | Transmission completion pulse |
| done_ack | input | 4 | Acknowledge code reported with completion |
| rsp_rcvd | input | 1 | Response packet received pulse |
| flag_clr | input | 4 | Write-one-to-clear strobes for the four flags |
| ack_valid | output | 1 | Acknowledge code valid |
| ack_code | output | 4 | Latched acknowledge code |
| end_irq | output | 1 | End-of-transaction interrupt |
| err_busy | output | 1 | Write rejected while a request was outstanding |
| err_ovf | output | 1 | Write rejected because the FIFO was full |

## Verification
A wrong FIFO pointer or count shows one cycle later at the output stream. It appears as an early or missing `out_valid`, a mis-ordered quadlet, a wrong end tag, or the wrong number of entries drained after an overflow. A wrong request or split state shows in the cycle after completion or after the response pulse. There, `tx_req`, `ack_valid`, `ack_code` or `end_irq` take the wrong value, or a host write in that window fails to raise `err_busy`. Mode gating errors show up on the next cycle as a FIFO entry that should not exist, or as `bulk_ready` asserted while the host owns the queue.

// File: rtl/hostq_pkg.sv
package hostq_pkg;
  localparam logic [3:0] ACK_PENDING = 4'h2;

  typedef enum logic [1:0] {
    TX_IDLE     = 2'd0,
    TX_REQ      = 2'd1,
    TX_WAIT_RSP = 2'd2
  } tx_state_e;

  localparam int CLR_ACKV = 0;
  localparam int CLR_IRQ  = 1;
  localparam int CLR_BUSY = 2;
  localparam int CLR_OVF  = 3;
endpackage

// File: rtl/hostq_fifo.sv
module hostq_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push && !full) wp <= nxt(wp);
      if (pop && !empty) rp <= nxt(rp);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hostq_wr_sel.sv
module hostq_wr_sel #(
  parameter int DW = 32
) (
  input  logic          cfg_fifo_en,
  input  logic          cfg_pktz,
  input  logic          cfg_hdr_ins,
  input  logic          cfg_data_sel,
  input  logic          host_fc_wr,
  input  logic [DW-1:0] host_fc_data,
  input  logic          host_upd_wr,
  input  logic [DW-1:0] host_upd_data,
  input  logic          bulk_valid,
  input  logic [DW-1:0] bulk_data,
  input  logic          bulk_last,
  input  logic          busy,
  input  logic          full,
  output logic          bulk_ready,
  output logic          push,
  output logic [DW:0]   push_data,
  output logic          commit,
  output logic          busy_hit,
  output logic          ovf_hit
);
  logic host_open, host_any, host_push;

  assign host_open  = cfg_fifo_en && !cfg_pktz && !cfg_hdr_ins && !cfg_data_sel;
  assign host_any   = host_open && (host_fc_wr || host_upd_wr);
  assign busy_hit   = host_any && busy;
  assign ovf_hit    = host_any && !busy && full;
  assign host_push  = host_any && !busy && !full;
  assign commit     = host_push && host_upd_wr;

  assign bulk_ready = cfg_fifo_en && cfg_data_sel && !full;
  assign push       = host_push || (bulk_valid && bulk_ready);

  always_comb begin
    if (host_open) begin
      push_data = host_upd_wr ? {1'b1, host_upd_data} : {1'b0, host_fc_data};
    end else begin
      push_data = {bulk_last, bulk_data};
    end
  end
endmodule

// File: rtl/hostq_txn.sv
module hostq_txn
  import hostq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic       done_valid,
  input  logic [3:0] done_ack,
  input  logic       rsp_rcvd,
  input  logic       split_dis,
  input  logic       busy_hit,
  input  logic       ovf_hit,
  input  logic [3:0] flag_clr,
  output logic       busy,
  output logic       tx_req,
  output logic       ack_valid,
  output logic [3:0] ack_code,
  output logic       end_irq,
  output logic       err_busy,
  output logic       err_ovf
);
  tx_state_e st;
  logic      done_now, defer, irq_set;

  assign tx_req   = (st == TX_REQ);
  assign busy     = (st != TX_IDLE);
  assign done_now = tx_req && done_valid;
  assign defer    = !split_dis && (done_ack == ACK_PENDING);
  assign irq_set  = (done_now && !defer) || (st == TX_WAIT_RSP && rsp_rcvd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      ack_valid <= 1'b0;
      ack_code  <= '0;
      end_irq   <= 1'b0;
      err_busy  <= 1'b0;
      err_ovf   <= 1'b0;
    end else begin
      case (st)
        TX_IDLE:     if (commit) st <= TX_REQ;
        TX_REQ:      if (done_valid) st <= defer ? TX_WAIT_RSP : TX_IDLE;
        TX_WAIT_RSP: if (rsp_rcvd) st <= TX_IDLE;
        default:     st <= TX_IDLE;
      endcase

      if (done_now)                ack_valid <= 1'b1;
      else if (flag_clr[CLR_ACKV]) ack_valid <= 1'b0;
      if (done_now)                ack_code  <= done_ack;

      if (irq_set)                 end_irq   <= 1'b1;
      else if (flag_clr[CLR_IRQ])  end_irq   <= 1'b0;

      if (busy_hit)                err_busy  <= 1'b1;
      else if (flag_clr[CLR_BUSY]) err_busy  <= 1'b0;

      if (ovf_hit)                 err_ovf   <= 1'b1;
      else if (flag_clr[CLR_OVF])  err_ovf   <= 1'b0;
    end
  end
endmodule

// File: rtl/hostq_tx_ctrl.sv
module hostq_tx_ctrl #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fifo_en,
  input  logic          cfg_pktz,
  input  logic          cfg_hdr_ins,
  input  logic          cfg_data_sel,
  input  logic          cfg_split_dis,
  input  logic          host_fc_wr,
  input  logic [DW-1:0] host_fc_data,
  input  logic          host_upd_wr,
  input  logic [DW-1:0] host_upd_data,
  input  logic          bulk_valid,
  output logic          bulk_ready,
  input  logic [DW-1:0] bulk_data,
  input  logic          bulk_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          tx_req,
  input  logic          done_valid,
  input  logic [3:0]    done_ack,
  input  logic          rsp_rcvd,
  input  logic [3:0]    flag_clr,
  output logic          ack_valid,
  output logic [3:0]    ack_code,
  output logic          end_irq,
  output logic          err_busy,
  output logic          err_ovf
);
  logic          q_push, q_full, q_empty, commit, busy, busy_hit, ovf_hit;
  logic [DW:0]   q_in, q_head;
  logic [CW-1:0] q_count;

  hostq_wr_sel #(.DW(DW)) u_sel (
    .cfg_fifo_en  (cfg_fifo_en),
    .cfg_pktz     (cfg_pktz),
    .cfg_hdr_ins  (cfg_hdr_ins),
    .cfg_data_sel (cfg_data_sel),
    .host_fc_wr   (host_fc_wr),
    .host_fc_data (host_fc_data),
    .host_upd_wr  (host_upd_wr),
    .host_upd_data(host_upd_data),
    .bulk_valid   (bulk_valid),
    .bulk_data    (bulk_data),
    .bulk_last    (bulk_last),
    .busy         (busy),
    .full         (q_full),
    .bulk_ready   (bulk_ready),
    .push         (q_push),
    .push_data    (q_in),
    .commit       (commit),
    .busy_hit     (busy_hit),
    .ovf_hit      (ovf_hit)
  );

  hostq_fifo #(.W(DW + 1), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (q_push),
    .push_data(q_in),
    .pop      (out_valid && out_ready),
    .head     (q_head),
    .full     (q_full),
    .empty    (q_empty),
    .count    (q_count)
  );

  assign out_valid = !q_empty;
  assign out_data  = q_head[DW-1:0];
  assign out_last  = q_head[DW];

  hostq_txn u_txn (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .done_valid(done_valid),
    .done_ack  (done_ack),
    .rsp_rcvd  (rsp_rcvd),
    .split_dis (cfg_split_dis),
    .busy_hit  (busy_hit),
    .ovf_hit   (ovf_hit),
    .flag_clr  (flag_clr),
    .busy      (busy),
    .tx_req    (tx_req),
    .ack_valid (ack_valid),
    .ack_code  (ack_code),
    .end_irq   (end_irq),
    .err_busy  (err_busy),
    .err_ovf   (err_ovf)
  );
endmodule

// File: rtl/hostq_tx_ctrl_chk.sv
module hostq_tx_ctrl_chk
  import hostq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_fifo_en,
  input logic          cfg_pktz,
  input logic          cfg_hdr_ins,
  input logic          cfg_data_sel,
  input logic          cfg_split_dis,
  input logic          host_fc_wr,
  input logic          host_upd_wr,
  input logic          bulk_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_last,
  input logic          tx_req,
  input logic          done_valid,
  input logic [3:0]    done_ack,
  input logic          ack_valid,
  input logic [3:0]    ack_code,
  input logic          end_irq,
  input logic          err_busy,
  input logic [CW-1:0] q_count
);
  p_bulk_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_data_sel |-> !bulk_ready);

  p_req_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> $past(host_upd_wr));

  p_ack_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && tx_req) |=> (ack_valid && !tx_req && ack_code == $past(done_ack)));

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && tx_req && done_ack == ACK_PENDING && !cfg_split_dis && !end_irq)
      |=> !end_irq);

  p_busy_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_fc_wr && tx_req && cfg_fifo_en && !cfg_pktz && !cfg_hdr_ins && !cfg_data_sel)
      |=> err_busy);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind hostq_tx_ctrl hostq_tx_ctrl_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_hostq_tx_ctrl.sv
module tb_hostq_tx_ctrl;
  localparam int DW    = 32;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_fifo_en = 0, cfg_pktz = 0, cfg_hdr_ins = 0, cfg_data_sel = 0, cfg_split_dis = 0;
  logic          host_fc_wr = 0, host_upd_wr = 0;
  logic [DW-1:0] host_fc_data = '0, host_upd_data = '0;
  logic          bulk_valid = 0, bulk_last = 0;
  logic [DW-1:0] bulk_data = '0;
  logic          bulk_ready;
  logic          out_valid, out_last;
  logic          out_ready = 0;
  logic [DW-1:0] out_data;
  logic          tx_req, done_valid = 0, rsp_rcvd = 0;
  logic [3:0]    done_ack = '0, flag_clr = '0;
  logic          ack_valid, end_irq, err_busy, err_ovf;
  logic [3:0]    ack_code;

  int n_cmp = 0;
  int n_bad = 0;

  always #4ns clk = ~clk;

  hostq_tx_ctrl #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    {cfg_fifo_en, cfg_pktz, cfg_hdr_ins, cfg_data_sel} = m;
  endtask

  task automatic fc_wr(input logic [DW-1:0] d);
    host_fc_wr = 1; host_fc_data = d; tick(); host_fc_wr = 0;
  endtask

  task automatic upd_wr(input logic [DW-1:0] d);
    host_upd_wr = 1; host_upd_data = d; tick(); host_upd_wr = 0;
  endtask

  task automatic clr_all();
    flag_clr = 4'hF; tick(); flag_clr = '0;
  endtask

  task automatic drain(output int n);
    n = 0;
    out_ready = 1;
    for (int i = 0; i < 2 * DEPTH + 2; i++) begin
      if (out_valid) n++;
      tick();
    end
    out_ready = 0;
  endtask

  task automatic pop_chk(input string tag, input logic [DW-1:0] d, input logic l);
    chk(tag, {31'd0, out_valid}, 32'd1);
    chk(tag, out_data, d);
    chk(tag, {31'd0, out_last}, {31'd0, l});
    out_ready = 1; tick(); out_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic exp_irq;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R12 reset state
    chk("R12 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R12 flags", {26'd0, tx_req, ack_valid, end_irq, err_busy, err_ovf, 1'b0}, 32'd0);
    chk("R12 ack_code", {28'd0, ack_code}, 32'd0);

    // R1 / R2 sweep of every mode combination
    for (int m = 0; m < 16; m++) begin
      set_mode(4'(m));
      tick();
      chk("R2 bulk_ready gate", {31'd0, bulk_ready}, {31'd0, (m[3] && m[0])});
      fc_wr(32'hA000 + m);
      chk("R1 host gate", {31'd0, out_valid}, {31'd0, (m == 8)});
      if (m == 8) chk("R3 body tag", {31'd0, out_last}, 32'd0);
      chk("R1 no flags", {30'd0, err_busy, err_ovf}, 32'd0);
      drain(n);
    end

    // R2 bulk stream locked out, then accepted when selected
    set_mode(4'b1000);
    bulk_valid = 1; bulk_data = 32'hB0B0; bulk_last = 1;
    tick(); tick();
    chk("R2 lockout ready", {31'd0, bulk_ready}, 32'd0);
    chk("R2 lockout fifo", {31'd0, out_valid}, 32'd0);
    set_mode(4'b1001);
    tick();
    bulk_valid = 0;
    pop_chk("R2 bulk beat", 32'hB0B0, 1'b1);
    chk("R2 single beat", {31'd0, out_valid}, 32'd0);

    // R5 completion ignored with no request
    set_mode(4'b1000);
    done_valid = 1; done_ack = 4'h1; tick(); done_valid = 0;
    chk("R5 ignored ack_valid", {31'd0, ack_valid}, 32'd0);

    // R3/R4/R11 packet order, back-pressure, request
    fc_wr(32'h11); fc_wr(32'h22); upd_wr(32'h33);
    chk("R4 tx_req", {31'd0, tx_req}, 32'd1);
    tick(); tick();
    chk("R11 held data", out_data, 32'h11);
    pop_chk("R11 q0", 32'h11, 1'b0);
    pop_chk("R11 q1", 32'h22, 1'b0);
    pop_chk("R4 final tag", 32'h33, 1'b1);

    // R9 busy write discarded
    fc_wr(32'h44);
    chk("R9 err_busy", {31'd0, err_busy}, 32'd1);
    chk("R9 discarded", {31'd0, out_valid}, 32'd0);
    upd_wr(32'h55);
    chk("R9 commit discarded", {31'd0, out_valid}, 32'd0);
    done_valid = 1; done_ack = 4'h0; tick(); done_valid = 0;
    chk("R5 req cleared", {31'd0, tx_req}, 32'd0);
    flag_clr = 4'b0100; tick(); flag_clr = '0;
    chk("R8 clear busy only", {29'd0, err_busy, ack_valid, end_irq}, 32'd3);
    clr_all();
    chk("R8 all clear", {29'd0, ack_valid, end_irq, err_busy}, 32'd0);

    // R10 overflow
    for (int i = 0; i <= DEPTH; i++) fc_wr(32'hC0 + i);
    chk("R10 err_ovf", {31'd0, err_ovf}, 32'd1);
    drain(n);
    chk("R10 kept count", n, DEPTH);
    clr_all();
    chk("R8 ovf clear", {31'd0, err_ovf}, 32'd0);

    // R5/R6/R7 sweep of every ack code with split on and off
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a++) begin
        cfg_split_dis = s[0];
        fc_wr(32'(a)); upd_wr(32'(a + 100));
        drain(n);
        chk("R4 two entries", n, 2);
        done_valid = 1; done_ack = 4'(a); tick(); done_valid = 0;
        exp_irq = (s == 1) || (a != 2);
        chk("R5 ack_valid", {31'd0, ack_valid}, 32'd1);
        chk("R5 ack_code", {28'd0, ack_code}, 32'(a));
        chk(exp_irq ? "R6 immediate irq" : "R7 held irq", {31'd0, end_irq}, {31'd0, exp_irq});
        if (!exp_irq) begin
          fc_wr(32'hDD);
          chk("R9 busy while waiting", {31'd0, err_busy}, 32'd1);
          chk("R7 no entry", {31'd0, out_valid}, 32'd0);
          rsp_rcvd = 1; tick(); rsp_rcvd = 0;
          chk("R7 irq after response", {31'd0, end_irq}, 32'd1);
        end
        clr_all();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule